// File: doc/BRIEF.md
# Four-Bank FFT Line Address Generator

This block sequences the memory addresses needed to store one range or azimuth line across four sample banks and then read it back for a radix-4 FFT. The line length is a power of four: 64, 256 or 1024 points, given as the number of radix-4 stages. The memory arrays and the butterfly datapath sit outside the block. The generator only tells them which bank, which in-bank address and which sample indices are active in each cycle.

A write run stores the line one 16-point segment per cycle. Segments are dealt to the banks in rotation, so any two adjacent segments always land in different banks. A read run walks every radix-4 stage in turn. In each cycle it names a pair of banks that together supply 32 samples. The bank pair flips every cycle, and the blocks are taken alternately from the bottom and the top of the line. After `start`, the block runs to the end without further input and reports when each stage ends and when the whole run ends.

Top module: `fft_bank_addr_gen`

## Requirements
- R1: While reset is held, and after it, `busy`, `wr_valid`, `rd_valid`, `stage_done` and `run_done` are 0 and `stage` is 0.
- R2: A `start` pulse is taken only while idle and only when `len_log4` is 3, 4 or 5. Any other value leaves the block idle. The line length N is 4 to the power `len_log4`. The first output cycle follows the accepting clock edge.
- R3: Write run (`mode`=0): there are N/16 cycles with `wr_valid`=1. Cycle s has `wr_index`=16·s, `wr_bank`=s mod 4 and `wr_base`=(s div 4)·16, where `wr_base` is the address of segment point 0 inside its bank.
- R4: Read run (`mode`=1): each stage has N/32 cycles with `rd_valid`=1. `rd_pair` is 0 (banks 0 and 1) in even cycles of the stage and 1 (banks 2 and 3) in odd cycles, so it alternates on every read cycle.
- R5: In read cycle c of a stage, the block is b=c when c is even and b=N/32−c when c is odd. The outputs are `rd_index`=32·b, the first of 32 consecutive points, and `rd_base`=(b div 2)·16, which is the same in-bank address for both banks of the pair.
- R6: Within each stage, every sample index 0..N−1 is covered exactly once by the read blocks.
- R7: A read run has `len_log4` stages. `stage` counts 0..`len_log4`−1 and changes only after a cycle with `stage_done`=1. `stage_done` is 1 exactly in the last read cycle of each stage.
- R8: `run_done` is 1 exactly in the last output cycle of a run. In the next cycle `busy` is 0 and `stage` is back to 0.
- R9: While busy, changes on `mode` and `len_log4` and further `start` pulses have no effect on the running sequence.
- R10: `wr_valid` and `rd_valid` are never 1 together, and neither is 1 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (taken while idle) |
| mode | input | 1 | 0 = write run, 1 = read run |
| len_log4 | input | 3 | Number of radix-4 stages (3..5) |
| busy | output | 1 | A run is in progress |
| wr_valid | output | 1 | Write outputs are valid |
| wr_bank | output | 2 | Bank receiving this segment |
| wr_base | output | 8 | In-bank address of segment point 0 |
| wr_index | output | 10 | Line index of segment point 0 |
| rd_valid | output | 1 | Read outputs are valid |
| rd_pair | output | 1 | 0 = banks 0/1, 1 = banks 2/3 |
| rd_base | output | 8 | In-bank address used in both banks of the pair |
| rd_index | output | 10 | Line index of the first of 32 points |
| stage | output | 3 | Current radix-4 stage |
| stage_done | output | 1 | Last read cycle of a stage |
| run_done | output | 1 | Last output cycle of the run |

## Verification
The hardest situation to reach is a disturbance in the middle of a run. A new `start`, a flipped `mode` and an out-of-range length arriving while the sequence is running must all leave the cycle-by-cycle address stream unchanged. The bench applies all three in the second cycle of both a write run and a read run and keeps comparing every cycle against its model. The wrap of the stage counter at the end of a 1024-point read is the other case that needs care. It is reached by running full five-stage reads and checking that the index coverage is complete in every stage.

// File: rtl/fft_bank_pkg.sv
// Shared definitions for the four-bank FFT address generator.
package fft_bank_pkg;
    typedef enum logic {
        RUN_WRITE = 1'b0,
        RUN_READ  = 1'b1
    } run_mode_e;
endpackage

// File: rtl/fab_seq_ctrl.sv
// Run sequencer: latches the run mode and length on an accepted start and
// steps a per-stage cycle counter and a stage counter until the run ends.
// Assumes MIN_LOG4 >= 3 so a read stage always has an even number of cycles.
module fab_seq_ctrl
    import fft_bank_pkg::*;
#(
    parameter int MIN_LOG4 = 3,
    parameter int MAX_LOG4 = 5,
    localparam int CNT_W   = 2 * MAX_LOG4 - 4,
    localparam int STG_W   = $clog2(MAX_LOG4 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode_in,
    input  logic [2:0]       len_log4,
    output logic             busy,
    output run_mode_e        mode_q,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-2:0] blocks_lo,
    output logic [STG_W-1:0] stage,
    output logic             last_step,
    output logic             last_stage
);
    logic [2:0]     log_q;
    logic [3:0]     shift;
    logic [CNT_W:0] steps;
    logic           len_ok;

    // Cycles per stage: N/16 for writes, N/32 for reads.
    always_comb begin
        shift      = {log_q, 1'b0} - ((mode_q == RUN_READ) ? 4'd5 : 4'd4);
        steps      = (CNT_W + 1)'(1) << shift;
        blocks_lo  = steps[CNT_W-2:0];
        last_step  = ({1'b0, cnt} == steps - (CNT_W + 1)'(1));
        last_stage = (STG_W'(log_q) == stage + STG_W'(1));
        len_ok     = (len_log4 >= 3'(MIN_LOG4)) && (len_log4 <= 3'(MAX_LOG4));
    end

    // Run state: accept start while idle, then count cycles and stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            mode_q <= RUN_WRITE;
            log_q  <= 3'(MIN_LOG4);
            cnt    <= '0;
            stage  <= '0;
        end else if (!busy) begin
            if (start && len_ok) begin
                busy   <= 1'b1;
                mode_q <= run_mode_e'(mode_in);
                log_q  <= len_log4;
                cnt    <= '0;
                stage  <= '0;
            end
        end else if (last_step) begin
            cnt <= '0;
            if (mode_q == RUN_READ && !last_stage) begin
                stage <= stage + STG_W'(1);
            end else begin
                stage <= '0;
                busy  <= 1'b0;
            end
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/fab_wr_map.sv
// Write mapping: segment s of 16 points goes to bank s mod 4 at in-bank
// address (s div 4)*16. Pure combinational; assumes 16-point segments.
module fab_wr_map #(
    parameter int MAX_LOG4 = 5,
    localparam int IDX_W   = 2 * MAX_LOG4,
    localparam int CNT_W   = IDX_W - 4,
    localparam int ADDR_W  = IDX_W - 2
) (
    input  logic [CNT_W-1:0]  seg,
    output logic [1:0]        bank,
    output logic [ADDR_W-1:0] base,
    output logic [IDX_W-1:0]  index
);
    // Segment number to bank, in-bank base and first point index.
    always_comb begin
        bank  = seg[1:0];
        base  = {seg[CNT_W-1:2], 4'b0000};
        index = {seg, 4'b0000};
    end
endmodule

// File: rtl/fab_rd_map.sv
// Read mapping: cycle c of a stage reads block c (even c) or blocks-c (odd c);
// a block is two segments sharing one in-bank address in a bank pair.
// Assumes the block count per stage is even; blocks_lo holds it modulo the
// counter width, which gives the right subtraction result.
module fab_rd_map #(
    parameter int MAX_LOG4 = 5,
    localparam int IDX_W   = 2 * MAX_LOG4,
    localparam int BLK_W   = IDX_W - 5,
    localparam int ADDR_W  = IDX_W - 2
) (
    input  logic [BLK_W-1:0]  cyc,
    input  logic [BLK_W-1:0]  blocks_lo,
    output logic              pair,
    output logic [ADDR_W-1:0] base,
    output logic [IDX_W-1:0]  index
);
    logic [BLK_W-1:0] blk;

    // Low block climbs on even cycles, high block descends on odd cycles.
    always_comb begin
        blk   = cyc[0] ? (blocks_lo - cyc) : cyc;
        pair  = blk[0];
        base  = {blk[BLK_W-1:1], 4'b0000};
        index = {blk, 5'b00000};
    end
endmodule

// File: rtl/fft_bank_addr_gen.sv
// Top of the four-bank FFT address generator. Sequences a write run
// (one 16-point segment per cycle) or a multi-stage read run (32 points per
// cycle from alternating bank pairs) for a line of 4^len_log4 points.
module fft_bank_addr_gen
    import fft_bank_pkg::*;
#(
    parameter int MIN_LOG4 = 3,
    parameter int MAX_LOG4 = 5,
    localparam int IDX_W   = 2 * MAX_LOG4,
    localparam int CNT_W   = IDX_W - 4,
    localparam int ADDR_W  = IDX_W - 2,
    localparam int STG_W   = $clog2(MAX_LOG4 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic [2:0]        len_log4,
    output logic              busy,
    output logic              wr_valid,
    output logic [1:0]        wr_bank,
    output logic [ADDR_W-1:0] wr_base,
    output logic [IDX_W-1:0]  wr_index,
    output logic              rd_valid,
    output logic              rd_pair,
    output logic [ADDR_W-1:0] rd_base,
    output logic [IDX_W-1:0]  rd_index,
    output logic [STG_W-1:0]  stage,
    output logic              stage_done,
    output logic              run_done
);
    run_mode_e        mode_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-2:0] blocks_lo;
    logic             last_step;
    logic             last_stage;

    fab_seq_ctrl #(.MIN_LOG4(MIN_LOG4), .MAX_LOG4(MAX_LOG4)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode),
        .len_log4(len_log4), .busy(busy), .mode_q(mode_q), .cnt(cnt),
        .blocks_lo(blocks_lo), .stage(stage), .last_step(last_step),
        .last_stage(last_stage)
    );

    fab_wr_map #(.MAX_LOG4(MAX_LOG4)) u_wr (
        .seg(cnt), .bank(wr_bank), .base(wr_base), .index(wr_index)
    );

    fab_rd_map #(.MAX_LOG4(MAX_LOG4)) u_rd (
        .cyc(cnt[CNT_W-2:0]), .blocks_lo(blocks_lo), .pair(rd_pair),
        .base(rd_base), .index(rd_index)
    );

    // Qualify the mapped addresses and derive the end-of-stage/run flags.
    always_comb begin
        wr_valid   = busy && (mode_q == RUN_WRITE);
        rd_valid   = busy && (mode_q == RUN_READ);
        stage_done = rd_valid && last_step;
        run_done   = busy && last_step && ((mode_q == RUN_WRITE) || last_stage);
    end
endmodule

// File: rtl/fft_bank_addr_gen_chk.sv
// Temporal checks on the address generator ports, bound into every instance.
module fft_bank_addr_gen_chk #(
    parameter int STG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             wr_valid,
    input logic             rd_valid,
    input logic             rd_pair,
    input logic [1:0]       wr_bank,
    input logic [STG_W-1:0] stage,
    input logic             stage_done,
    input logic             run_done
);
    // R10
    valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rd_valid) && (busy || (!wr_valid && !rd_valid)));

    // R4
    pair_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (!rd_valid || rd_pair != $past(rd_pair)));

    // R3
    bank_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (!wr_valid || wr_bank == $past(wr_bank) + 2'd1));

    // R7
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !stage_done) |=> (!busy || $stable(stage)));

    // R7
    stage_done_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_done |-> rd_valid);

    // R8
    run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> (!busy && stage == '0));
endmodule

bind fft_bank_addr_gen fft_bank_addr_gen_chk #(.STG_W(STG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wr_valid(wr_valid),
    .rd_valid(rd_valid), .rd_pair(rd_pair), .wr_bank(wr_bank),
    .stage(stage), .stage_done(stage_done), .run_done(run_done)
);

// File: tb/fft_bank_addr_gen_bench.sv
`timescale 1ns/1ps
module fft_bank_addr_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mode = 1'b0;
    logic [2:0] len_log4 = 3'd3;
    logic       busy, wr_valid, rd_valid, rd_pair, stage_done, run_done;
    logic [1:0] wr_bank;
    logic [7:0] wr_base, rd_base;
    logic [9:0] wr_index, rd_index;
    logic [2:0] stage;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit seen [1024];

    fft_bank_addr_gen u_fft_bank_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .len_log4(len_log4), .busy(busy), .wr_valid(wr_valid),
        .wr_bank(wr_bank), .wr_base(wr_base), .wr_index(wr_index),
        .rd_valid(rd_valid), .rd_pair(rd_pair), .rd_base(rd_base),
        .rd_index(rd_index), .stage(stage), .stage_done(stage_done),
        .run_done(run_done)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic check_idle(input string req);
        chk_eq({req, " busy"}, int'(busy), 0);
        chk_eq({req, " wr_valid"}, int'(wr_valid), 0);
        chk_eq({req, " rd_valid"}, int'(rd_valid), 0);
        chk_eq({req, " stage_done"}, int'(stage_done), 0);
        chk_eq({req, " run_done"}, int'(run_done), 0);
        chk_eq({req, " stage"}, int'(stage), 0);
    endtask

    // Drive one run and compare each output cycle against the model.
    task automatic run(input bit rd, input int lg, input bit disturb);
        int n = 1 << (2 * lg);
        @(negedge clk);
        mode = rd; len_log4 = 3'(lg); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!rd) begin
            for (int s = 0; s < n / 16; s++) begin
                if (s == 2) start = 1'b0;
                chk_eq("R10 rd_valid in write", int'(rd_valid), 0);
                chk_eq("R3 wr_valid", int'(wr_valid), 1);
                chk_eq("R3 wr_bank", int'(wr_bank), s % 4);
                chk_eq("R3 wr_base", int'(wr_base), (s / 4) * 16);
                chk_eq("R3 wr_index", int'(wr_index), 16 * s);
                chk_eq("R8 run_done", int'(run_done), int'(s == n / 16 - 1));
                if (disturb && s == 1) begin // R9
                    mode = 1'b1; len_log4 = 3'd6; start = 1'b1;
                end
                @(negedge clk);
            end
        end else begin
            int nb = n / 32;
            for (int st = 0; st < lg; st++) begin
                for (int i = 0; i < 1024; i++) seen[i] = 1'b0;
                for (int c = 0; c < nb; c++) begin
                    int b = (c % 2 == 0) ? c : nb - c;
                    if (st == 0 && c == 2) start = 1'b0;
                    chk_eq("R10 wr_valid in read", int'(wr_valid), 0);
                    chk_eq("R4 rd_valid", int'(rd_valid), 1);
                    chk_eq("R4 rd_pair", int'(rd_pair), c % 2);
                    chk_eq("R5 rd_index", int'(rd_index), 32 * b);
                    chk_eq("R5 rd_base", int'(rd_base), (b / 2) * 16);
                    chk_eq("R7 stage", int'(stage), st);
                    chk_eq("R7 stage_done", int'(stage_done), int'(c == nb - 1));
                    chk_eq("R8 run_done", int'(run_done),
                           int'(c == nb - 1 && st == lg - 1));
                    for (int k = 0; k < 32; k++) begin
                        int ix = int'(rd_index) + k;
                        if (ix < 1024) begin
                            if (seen[ix]) chk(1'b0, "R6 index read twice", ix, -1);
                            seen[ix] = 1'b1;
                        end
                    end
                    if (disturb && st == 0 && c == 1) begin // R9
                        mode = 1'b0; len_log4 = 3'd1; start = 1'b1;
                    end
                    @(negedge clk);
                end
                begin
                    int cnt_seen = 0;
                    for (int i = 0; i < n; i++) cnt_seen += int'(seen[i]);
                    chk_eq("R6 indices covered per stage", cnt_seen, n);
                end
            end
        end
        chk_eq("R8 busy after run", int'(busy), 0);
        chk_eq("R8 stage after run", int'(stage), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        // R2: out-of-range lengths are refused
        start = 1'b1; len_log4 = 3'd2;
        @(negedge clk);
        chk_eq("R2 len 2 refused", int'(busy), 0);
        len_log4 = 3'd6;
        @(negedge clk);
        chk_eq("R2 len 6 refused", int'(busy), 0);
        start = 1'b0;
        @(negedge clk);
        check_idle("R2 still idle");

        run(1'b0, 3, 1'b0);
        run(1'b0, 4, 1'b0);
        run(1'b0, 5, 1'b0);
        run(1'b1, 3, 1'b0);
        run(1'b1, 4, 1'b0);
        run(1'b1, 5, 1'b0);
        run(1'b0, 4, 1'b1);
        run(1'b1, 5, 1'b1);
        @(negedge clk);
        check_idle("R10 idle at end");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule